// File: doc/BRIEF.md
# Asymmetric-Step Wrapping Counter

This block is a three-bit synchronous counter whose step depends on a single direction input. With the direction input high, every rising clock edge advances the count by two. With it low, every edge moves the count back by one. Both directions wrap modulo eight, so the count never leaves the range 0 to 7. There is no enable: the count changes on every clock edge that is not a reset edge.

Each state bit is held in a J-K style storage cell. A combinational stage computes the wanted next count. An excitation stage then turns the present and next bit values into per-bit J and K terms. The count seen at the output behaves as a plain counter, and the J and K wires stay internal. A synchronous, active-high reset returns the count to zero.

Top module: `asym_step_counter`

## Requirements
- R1: When `rst_i` is 1 at a rising edge of `clk_i`, `count_o` becomes 0 after that edge, whatever the value of `up_i`.
- R2: When `rst_i` is 0 and `up_i` is 1 at a rising edge, the new `count_o` is (old `count_o` + 2) mod 8. For example 5 goes to 7, 6 goes to 0 and 7 goes to 1.
- R3: When `rst_i` is 0 and `up_i` is 0 at a rising edge, the new `count_o` is (old `count_o` − 1) mod 8. For example 0 goes to 7.
- R4: Each count bit is updated only through its J and K terms, by the rule {J,K} = 00 holds, 10 sets, 01 clears and 11 toggles. The next value of each bit therefore equals (J and not Q) or (not K and Q).
- R5: `count_o` changes only at rising edges of `clk_i`. It holds its value between edges even when `up_i` changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on the rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| up_i | input | 1 | Step select: 1 adds two, 0 subtracts one |
| count_o | output | 3 | Present count value |

## Verification
The assertions check the following on every cycle: the add-two and subtract-one steps with wrap, the return to zero after reset, and the agreement between each bit's next value and its J/K terms. These properties are stated in modular arithmetic and do not depend on the way the next-state stage is built. The bench makes an exhaustive sweep that starts from all eight present states under both step directions. That sweep shows the specific wrap points, 6 to 0, 7 to 1 and 0 to 7, as concrete values. Only the bench's scenarios show that a reset applied in the middle of a run overrides a high `up_i`, and that a change of `up_i` between clock edges leaves the output untouched.

// File: rtl/asym_step_pkg.sv
package asym_step_pkg;

  typedef enum logic {
    STEP_DOWN = 1'b0,
    STEP_UP   = 1'b1
  } step_dir_e;

  localparam int unsigned UP_AMOUNT   = 2;
  localparam int unsigned DOWN_AMOUNT = 1;

  // Modular step on a counter of the given width.
  function automatic int unsigned wrap_step(int unsigned cur, logic up, int unsigned width);
    int unsigned modulus;
    modulus = 32'd1 << width;
    if (up) return (cur + UP_AMOUNT) % modulus;
    return (cur + modulus - DOWN_AMOUNT) % modulus;
  endfunction

  // Characteristic equation of a J-K cell.
  function automatic logic jk_next(logic q, logic j, logic k);
    return (j & ~q) | (~k & q);
  endfunction

endpackage

// File: rtl/asym_step_next.sv
module asym_step_next
  import asym_step_pkg::*;
#(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] nxt_o
);

  localparam int unsigned PAD = 32 - WIDTH;

  logic [31:0] cur_ext;
  logic [31:0] nxt_ext;

  always_comb begin
    cur_ext = {{PAD{1'b0}}, cur_i};
    nxt_ext = wrap_step(cur_ext, up_i, WIDTH);
    nxt_o   = nxt_ext[WIDTH-1:0];
  end

endmodule

// File: rtl/asym_step_jk_exc.sv
module asym_step_jk_exc #(
  parameter int unsigned WIDTH = 3
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] nxt_i,
  output logic [WIDTH-1:0] j_o,
  output logic [WIDTH-1:0] k_o
);

  // A bit that must rise gets J, a bit that must fall gets K.
  for (genvar b = 0; b < WIDTH; b++) begin : g_exc
    assign j_o[b] =  nxt_i[b] & ~cur_i[b];
    assign k_o[b] = ~nxt_i[b] &  cur_i[b];
  end

endmodule

// File: rtl/asym_step_jk_cell.sv
module asym_step_jk_cell (
  input  logic clk_i,
  input  logic rst_i,
  input  logic j_i,
  input  logic k_i,
  output logic q_o
);

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      q_o <= 1'b0;
    end else begin
      unique case ({j_i, k_i})
        2'b00:   q_o <= q_o;
        2'b10:   q_o <= 1'b1;
        2'b01:   q_o <= 1'b0;
        default: q_o <= ~q_o;
      endcase
    end
  end

endmodule

// File: rtl/asym_step_counter.sv
module asym_step_counter #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             up_i,
  output logic [WIDTH-1:0] count_o
);

  logic [WIDTH-1:0] state_q;
  logic [WIDTH-1:0] next_state;
  logic [WIDTH-1:0] j_vec;
  logic [WIDTH-1:0] k_vec;

  asym_step_next #(.WIDTH(WIDTH)) u_next (
    .cur_i (state_q),
    .up_i  (up_i),
    .nxt_o (next_state)
  );

  asym_step_jk_exc #(.WIDTH(WIDTH)) u_exc (
    .cur_i (state_q),
    .nxt_i (next_state),
    .j_o   (j_vec),
    .k_o   (k_vec)
  );

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    asym_step_jk_cell u_cell (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .j_i   (j_vec[b]),
      .k_i   (k_vec[b]),
      .q_o   (state_q[b])
    );
  end

  assign count_o = state_q;

endmodule

// File: rtl/asym_step_counter_chk.sv
module asym_step_counter_chk #(
  parameter int unsigned WIDTH = 3
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic             up_i,
  input logic [WIDTH-1:0] count_o,
  input logic [WIDTH-1:0] j_vec,
  input logic [WIDTH-1:0] k_vec
);

  localparam logic [WIDTH-1:0] UP_INC = WIDTH'(2);
  localparam logic [WIDTH-1:0] DN_DEC = WIDTH'(1);

  // R1: reset returns the count to zero
  a_r1_reset_zero: assert property (@(posedge clk_i)
    rst_i |=> (count_o == '0));

  // R2: add-two step with wrap
  a_r2_up_step: assert property (@(posedge clk_i) disable iff (rst_i)
    up_i |=> (count_o == $past(count_o) + UP_INC));

  // R3: subtract-one step with wrap
  a_r3_down_step: assert property (@(posedge clk_i) disable iff (rst_i)
    !up_i |=> (count_o == $past(count_o) - DN_DEC));

  // R4: the stored bits follow the J-K characteristic equation
  a_r4_jk_rule: assert property (@(posedge clk_i) disable iff (rst_i)
    1'b1 |=> (count_o == (($past(j_vec) & ~$past(count_o)) |
                          (~$past(k_vec) & $past(count_o)))));

  // R4: never a toggle request, the set/clear terms stay exclusive per bit
  a_r4_jk_excl: assert property (@(posedge clk_i) disable iff (rst_i)
    (j_vec & k_vec) == '0);

endmodule

bind asym_step_counter asym_step_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i   (clk_i),
  .rst_i   (rst_i),
  .up_i    (up_i),
  .count_o (count_o),
  .j_vec   (j_vec),
  .k_vec   (k_vec)
);

// File: tb/test_asym_step_counter.sv
`timescale 1ns/1ps
module test_asym_step_counter;

  localparam int W = 3;
  localparam int MOD = 1 << W;

  logic         clk = 1'b0;
  logic         rst;
  logic         up;
  logic [W-1:0] count;

  int checks = 0;
  int errors = 0;
  int exp_cnt = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  asym_step_counter #(.WIDTH(W)) i_asym_step_counter (
    .clk_i   (clk),
    .rst_i   (rst),
    .up_i    (up),
    .count_o (count)
  );

  task automatic check(string req, int expv);
    checks++;
    if (int'(count) != expv) begin
      errors++;
      $display("FAIL %s: count=%0d expected=%0d", req, count, expv);
    end
  endtask

  // One clock: drive on falling edge, sample 1 ns after rising edge.
  task automatic tick(logic r, logic u);
    @(negedge clk);
    rst = r;
    up  = u;
    @(posedge clk);
    #1;
    if (r) exp_cnt = 0;
    else if (u) exp_cnt = (exp_cnt + 2) % MOD;
    else exp_cnt = (exp_cnt + MOD - 1) % MOD;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    checks++;
    $display("FAIL watchdog: count=%0d expected=run end", count);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    up  = 1'b0;
    tick(1'b1, 1'b0);
    check("R1 reset value", 0);

    // Exhaustive: every present state, both step directions (R2, R3).
    for (int s = 0; s < MOD; s++) begin
      for (int d = 0; d < 2; d++) begin
        tick(1'b1, 1'b1);
        check("R1 reset with up high", 0);
        for (int n = 0; n < (MOD - s) % MOD; n++) begin
          tick(1'b0, 1'b0);
          check("R3 walk down", exp_cnt);
        end
        check("R3 reached start state", s);
        tick(1'b0, d[0]);
        if (d == 1) check("R2 add two from state", (s + 2) % MOD);
        else        check("R3 subtract one from state", (s + MOD - 1) % MOD);
      end
    end

    // Named wrap points.
    tick(1'b1, 1'b0);
    tick(1'b0, 1'b0);
    check("R3 zero wraps to seven", 7);
    tick(1'b0, 1'b1);
    check("R2 seven wraps to one", 1);
    tick(1'b0, 1'b1); tick(1'b0, 1'b1);
    check("R2 reach five", 5);
    tick(1'b0, 1'b1);
    check("R2 five to seven", 7);
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b1);
    check("R2 six wraps to zero", 0);

    // R4: long mixed run, every bit set, cleared and held via J/K.
    for (int n = 0; n < 40; n++) begin
      tick(1'b0, logic'((n * 7 + n / 3) % 2));
      check("R4 mixed sequence", exp_cnt);
    end

    // R1: reset mid-run overrides up.
    tick(1'b1, 1'b1);
    check("R1 reset mid-run", 0);

    // R5: input changes between edges do not move the count.
    tick(1'b0, 1'b1);
    check("R2 step before hold test", 2);
    @(negedge clk);
    up = 1'b0;
    #1;
    check("R5 stable after up falls", 2);
    up = 1'b1;
    #0.5;
    check("R5 stable after up rises", 2);

    finish_run();
  end

endmodule